// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands over many clock cycles. It uses one adder that is as wide as an operand, one multiplicand register, and one double-width product register. At the start of a multiply, the low half of the product register holds the multiplier. Each cycle, the unit looks at bit 0 of the product register. If that bit is set, the unit adds the multiplicand into the high half. It then shifts the whole register right by one place in the same cycle. The carry out of the add moves into the top bit, so no part of the sum is lost. After one pass per operand bit, the register holds the full unsigned product.

A caller pulses `start` with the operands on `a` and `b` while the unit is idle. `busy` stays high during the iterations. `done` pulses for one cycle when `product` is valid. The result then stays on `product` until the next accepted start. With the default 32-bit operands, `done` rises 32 cycles after the edge that accepts `start`.

Top module: `shmul_top`

## Requirements
- R1: During reset and in the first cycle after it, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is low loads the operands. In the next cycle, `busy` is 1, the upper half of `product` is zero, and the lower half equals the `b` that was sampled.
- R3: While `busy` is high, each clock performs one iteration. If product bit 0 is 1, the register becomes ((upper half + multiplicand) with its carry, concatenated with the lower half) shifted right by one. If bit 0 is 0, the whole register shifts right by one with a zero entering bit 63.
- R4: Exactly OP_W iterations run. `done` is high for exactly one cycle, OP_W cycles after the accepting edge, and `busy` is low in that cycle.
- R5: When `done` is high, `product` equals the full 64-bit unsigned product a*b. This includes all-ones operands, where every add carries out.
- R6: A `start` sampled while `busy` is high is ignored. The running multiply keeps its operands, its timing and its result.
- R7: While `busy` is low and no `start` is sampled, `product` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to load operands and begin a multiply |
| a | input | OP_W | Multiplicand, unsigned |
| b | input | OP_W | Multiplier, unsigned |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| product | output | 2*OP_W | Product register; holds the result after done |

## Verification
The checker watches several things on every cycle. It checks that a load is correct and that `done` is a single pulse with `busy` low. It counts the run length from the accepting edge to `done`. It checks that the lower half shifts by exactly one place per busy cycle and that the idle product holds. It also checks the final result against the product of the operands that were accepted. Other behaviours only show up in the bench's scenarios, which run against a behavioural per-clock model. These are the carry chain under all-ones operands, the zero and single-bit cases, and a `start` pulse injected during a run.

// File: rtl/shmul_pkg.sv
// Shared types for the shift-add multiplier.
// Assumes: nothing beyond a two-state control sequence.
package shmul_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } shmul_state_e;
endpackage

// File: rtl/shmul_adder.sv
// Ripple-carry adder of W bits with carry out in the top bit of sum.
// Assumes: W >= 1; purely combinational.
module shmul_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W:0]   sum
);
    logic [W:0] carry;

    assign carry[0] = 1'b0;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = x[i] ^ y[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end

    assign sum[W] = carry[W];
endmodule

// File: rtl/shmul_ctrl.sv
// Sequencer: accepts start when idle, counts OP_W iterations, pulses done.
// Assumes: OP_W >= 2; start is ignored while running.
module shmul_ctrl
    import shmul_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(OP_W);

    shmul_state_e     state_q;
    logic [CNT_W-1:0] iter_q;
    logic             last_iter;

    assign load      = start && (state_q == ST_IDLE);
    assign step      = (state_q == ST_RUN);
    assign busy      = step;
    assign last_iter = (iter_q == CNT_W'(OP_W - 1));

    // State, iteration counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state_q <= ST_RUN;
                iter_q  <= '0;
            end else if (step) begin
                iter_q <= iter_q + 1'b1;
                if (last_iter) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/shmul_datapath.sv
// Multiplicand register, product register and one OP_W-bit adder.
// The low half of the product register starts out holding the multiplier.
// Assumes: load and step are never high together.
module shmul_datapath #(
    parameter int OP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [2*OP_W-1:0] product
);
    localparam int PW = 2 * OP_W;

    logic [OP_W-1:0] mcand_q;
    logic [PW-1:0]   prod_q;
    logic [OP_W-1:0] addend;
    logic [OP_W:0]   upper_sum;
    logic [PW-1:0]   prod_next;

    // Addend is the multiplicand only when the tested bit is set.
    always_comb begin
        addend = prod_q[0] ? mcand_q : '0;
    end

    shmul_adder #(.W(OP_W)) u_adder (
        .x   (prod_q[PW-1:OP_W]),
        .y   (addend),
        .sum (upper_sum)
    );

    // Carry lands in the top bit; the register shifts right by one.
    always_comb begin
        prod_next = {upper_sum, prod_q[OP_W-1:1]};
    end

    // Operand load and per-iteration update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= a;
            prod_q  <= {{OP_W{1'b0}}, b};
        end else if (step) begin
            prod_q  <= prod_next;
        end
    end

    assign product = prod_q;
endmodule

// File: rtl/shmul_top.sv
// Sequential unsigned multiplier: OP_W x OP_W -> 2*OP_W bits.
// Takes OP_W cycles after the accepting edge.
// Assumes: synchronous active-low reset; operands are sampled only with start.
module shmul_top #(
    parameter int OP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic              busy,
    output logic              done,
    output logic [2*OP_W-1:0] product
);
    logic load;
    logic step;

    shmul_ctrl #(.OP_W(OP_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    shmul_datapath #(.OP_W(OP_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .a       (a),
        .b       (b),
        .product (product)
    );
endmodule

// File: rtl/shmul_chk.sv
// Port-level checker for shmul_top, attached by bind below.
// Assumes: the same reset and clock as the checked block.
module shmul_chk #(
    parameter int OP_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OP_W-1:0]   a,
    input logic [OP_W-1:0]   b,
    input logic              busy,
    input logic              done,
    input logic [2*OP_W-1:0] product
);
    localparam int RW = $clog2(OP_W + 1) + 1;

    logic [RW-1:0]     run_cnt;
    logic [OP_W-1:0]   cap_a;
    logic [OP_W-1:0]   cap_b;
    logic [2*OP_W-1:0] want;

    // Capture accepted operands and count cycles since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            cap_a   <= '0;
            cap_b   <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
            cap_a   <= a;
            cap_b   <= b;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign want = {{OP_W{1'b0}}, cap_a} * {{OP_W{1'b0}}, cap_b};

    AST_LOAD_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && product == {{OP_W{1'b0}}, $past(b)}); // R2
    AST_LOW_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> product[OP_W-2:0] == $past(product[OP_W-1:1])); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> run_cnt == RW'(OP_W)); // R6
    AST_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product == want); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(product)); // R7
endmodule

bind shmul_top shmul_chk #(.OP_W(OP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .a       (a),
    .b       (b),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/shmul_top_tb.sv
// Bench: behavioural per-clock model plus directed scenarios.
module shmul_top_tb;
    localparam int OP_W = 32;
    localparam int PW   = 2 * OP_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [OP_W-1:0] a = '0;
    logic [OP_W-1:0] b = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int checks = 0;
    int fails  = 0;

    // Behavioural model state.
    logic [PW-1:0]   m_prod = '0;
    logic [OP_W-1:0] m_mc = '0;
    logic            m_busy = 1'b0;
    logic            m_done = 1'b0;
    int              m_left = 0;

    always #2 clk = ~clk;

    shmul_top #(.OP_W(OP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
        .busy(busy), .done(done), .product(product)
    );

    // Model update on each rising edge (inputs change only on falling edges).
    always @(posedge clk) begin
        logic [PW:0] wide;
        if (!rst_n) begin
            m_prod <= '0; m_busy <= 1'b0; m_done <= 1'b0; m_left <= 0;
        end else begin
            m_done <= 1'b0;
            if (start && !m_busy) begin
                m_mc <= a; m_prod <= {{OP_W{1'b0}}, b};
                m_busy <= 1'b1; m_left <= OP_W;
            end else if (m_busy) begin
                wide = {1'b0, m_prod};
                if (m_prod[0]) wide = wide + ({1'b0, m_mc} << OP_W);
                m_prod <= wide[PW:1];
                m_left <= m_left - 1;
                if (m_left == 1) begin
                    m_busy <= 1'b0; m_done <= 1'b1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R3 step behaviour).
    always @(negedge clk) begin
        if (rst_n) begin
            check(product == m_prod, "R3 product", product, m_prod);
            check(busy == m_busy && done == m_done, "R3 busy/done",
                  {busy, done}, {m_busy, m_done});
        end
    end

    // One multiply; inject >= 0 drives a stray start that many cycles into the run.
    task automatic run_mul(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y,
                           input int inject);
        logic [PW-1:0] exp;
        logic [PW-1:0] held;
        int k;
        exp = {{OP_W{1'b0}}, x} * {{OP_W{1'b0}}, y};
        @(negedge clk);
        start = 1'b1; a = x; b = y;
        @(negedge clk);
        start = 1'b0; a = ~x; b = ~y;
        check(busy && product == {{OP_W{1'b0}}, y}, "R2 load", product,
              {{OP_W{1'b0}}, y});
        k = 0;
        while (!done && k < OP_W + 4) begin
            if (k == inject) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            k++;
        end
        check(k == OP_W, (inject >= 0) ? "R6 timing" : "R4 latency", PW'(k), PW'(OP_W));
        check(!busy, "R4 busy low at done", PW'(busy), '0);
        check(product == exp, (inject >= 0) ? "R6 result" : "R5 result", product, exp);
        held = product;
        @(negedge clk);
        check(!done, "R4 single pulse", PW'(done), '0);
        repeat (3) @(negedge clk);
        check(product == held, "R7 idle hold", product, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && product == '0, "R1 reset", product, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && product == '0, "R1 after reset", product, '0);
        run_mul(32'd2, 32'd3, -1);
        run_mul(32'd0, 32'hDEADBEEF, -1);
        run_mul(32'h89ABCDEF, 32'd0, -1);
        run_mul(32'hFFFFFFFF, 32'hFFFFFFFF, -1);
        run_mul(32'd1, 32'hFFFFFFFF, -1);
        run_mul(32'h80000000, 32'h80000000, -1);
        run_mul(32'h12345678, 32'h9ABCDEF0, 5);
        run_mul(32'hCAFEF00D, 32'h0BADF00D, 0);
        for (int i = 1; i <= 6; i++)
            run_mul(32'h9E3779B9 * i, 32'h7F4A7C15 ^ (i * 32'h01000193), -1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failure but still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule